// File: doc/BRIEF.md
# Sequential-Status Run-Length Compressor

This block sits between a processor's per-instruction status stream and an on-chip trace buffer. Each cycle it may receive one 5-bit status code. The code for "one sequential instruction executed" (value 1) is not forwarded directly. The block counts consecutive occurrences of it and later reports the whole run as a single entry. Every other code passes through unchanged and in its original order, but only after any pending run has been reported.

A pending run is written out for any one of four reasons:
- a different status code is accepted;
- the run reaches its maximum length;
- the debug data-capture strobe fires;
- the explicit flush pin is raised.

When a different code causes the flush, the run entry leaves first and the code that caused it follows on the next output beat. A run of length 1 is reported as plain code 1. Longer runs use reserved codes that encode the length directly.

Both stream ports use valid/ready. A beat transfers on a rising clock edge where valid and ready are both high.
- Input side: `in_ready` depends only on the internal queue, never on `in_valid`. It drops while two or more entries are waiting.
- Output side: once `out_valid` is high, it stays high and `out_code` holds steady until `out_ready` takes the beat.

The capture and flush pins are plain single-cycle strobes with no handshake. If the queue is full, the request is remembered and carried out as soon as a slot is free.

Top module: `seq_status_rlc`

## Requirements
- R1: While reset is held and in the cycle after it is released, `out_valid` is 0 and `in_ready` is 1. Reset discards any partial run without emitting an entry.
- R2: A status code other than 1 (codes 0 and 2..19), accepted with no run pending, appears once and unchanged on `out_code`, in acceptance order.
- R3: When n consecutive code-1 beats (1 <= n <= 11) are followed by an accepted code X other than 1, the block emits the run entry and then X on the next beat. The run entry is code 1 for n = 1 and code n+19 for n >= 2.
- R4: The maximum run is 12. The 12th consecutive code-1 beat emits code 31 at once and restarts the count, so 12 ones give one entry of 31. Ten consecutive ones followed by another event give exactly one entry, code 29.
- R5: A `capture` strobe flushes the pending run as one entry. If code 1 is accepted in the same cycle as the strobe, that beat is counted in the flushed run.
- R6: The `flush` pin drains a pending run in the same way as `capture`. With no run pending, it emits nothing.
- R7: No entry is lost or duplicated under back-pressure. `out_code` is stable while `out_valid` is high and `out_ready` is low. `in_ready` is 1 whenever at most one entry is waiting.
- R8: Code 20 is never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Status code offered |
| in_code | input | 5 | Status code |
| in_ready | output | 1 | Block can take a status code this cycle |
| capture | input | 1 | Debug data-capture strobe |
| flush | input | 1 | Drain any pending run |
| out_valid | output | 1 | Compressed entry offered |
| out_code | output | 5 | Compressed entry |
| out_ready | input | 1 | Trace buffer takes the entry |

## Verification
The assertions assume the producer never offers codes 20..31, which are reserved for run entries. They also assume `capture` and `flush` are ordinary synchronous pulses. The stimulus sends only codes 0..19 and drives every input at the falling edge. The bench holds each offered code steady until the beat is accepted. The sweeps cover every run length from 0 to twice the maximum under each of the three flush triggers. The same stream is then replayed with a pseudo-random `out_ready` pattern, so the stall and deferred-drain paths are exercised.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int CODE_W = 5;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t SEQ_CODE = code_t'(1);
endpackage

// File: rtl/rlc_accum.sv
module rlc_accum
  import rlc_pkg::*;
#(
  parameter int MAX_RUN  = 12,
  parameter int RUN_BASE = 20,
  localparam int CNT_W   = $clog2(MAX_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  code_t            code,
  input  logic             capture,
  input  logic             flush,
  input  logic             room_i,
  output logic [1:0]       push_n,
  output code_t            push0,
  output code_t            push1,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, mid;
  logic drain_q, drain_d, drain_req, drain_done, room;

  function automatic code_t run_code(input logic [CNT_W-1:0] len);
    if (len == CNT_W'(1)) return SEQ_CODE;
    return code_t'(RUN_BASE) + code_t'(len) - code_t'(1);
  endfunction

  assign drain_req = drain_q | capture | flush;
  assign room      = acc | room_i;

  always_comb begin
    mid    = cnt_q;
    push_n = 2'd0;
    push0  = '0;
    push1  = '0;
    if (acc) begin
      if (code == SEQ_CODE) begin
        if (cnt_q == CNT_W'(MAX_RUN - 1)) begin
          push0  = run_code(CNT_W'(MAX_RUN));
          push_n = 2'd1;
          mid    = '0;
        end else begin
          mid = cnt_q + CNT_W'(1);
        end
      end else begin
        if (cnt_q != '0) begin
          push0  = run_code(cnt_q);
          push1  = code;
          push_n = 2'd2;
        end else begin
          push0  = code;
          push_n = 2'd1;
        end
        mid = '0;
      end
    end
    drain_done = drain_req & (room | (mid == '0));
    if (drain_req && room && mid != '0) begin
      if (push_n == 2'd0) begin
        push0  = run_code(mid);
        push_n = 2'd1;
      end else begin
        push1  = run_code(mid);
        push_n = 2'd2;
      end
      mid = '0;
    end
    cnt_d   = mid;
    drain_d = drain_req & ~drain_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      drain_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      drain_q <= drain_d;
    end
  end

  assign cnt_o = cnt_q;

  // R4: the held count never reaches the maximum
  a_r4_count_below_max: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_RUN));
  // R4: the saturating beat restarts the count
  a_r4_sat_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && code == SEQ_CODE && cnt_q == CNT_W'(MAX_RUN - 1)) |=> cnt_q == '0);
  // R5/R6: a remembered drain with room empties the counter
  a_r5_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_q && room_i && !acc) |=> cnt_q == '0);
endmodule

// File: rtl/rlc_queue.sv
module rlc_queue
  import rlc_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int PW   = $clog2(DEPTH),
  localparam int OW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    push_n,
  input  code_t         d0,
  input  code_t         d1,
  input  logic          pop,
  output code_t         head,
  output logic          nonempty,
  output logic [OW-1:0] occ_o
);
  logic [PW-1:0] wr_q, rd_q, wr_nx1;
  logic [OW-1:0] occ_q;
  logic [DEPTH*CODE_W-1:0] mem_flat;
  logic pop_eff;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input int k);
    int s;
    s = (int'(p) + k) % DEPTH;
    return PW'(s);
  endfunction

  assign wr_nx1  = step(wr_q, 1);
  assign pop_eff = pop & (occ_q != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    code_t slot_q;
    always_ff @(posedge clk) begin
      if (push_n != 2'd0 && wr_q == PW'(i)) slot_q <= d0;
      else if (push_n == 2'd2 && wr_nx1 == PW'(i)) slot_q <= d1;
    end
    assign mem_flat[i*CODE_W +: CODE_W] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      wr_q  <= step(wr_q, int'(push_n));
      rd_q  <= pop_eff ? step(rd_q, 1) : rd_q;
      occ_q <= occ_q + OW'(push_n) - OW'(pop_eff);
    end
  end

  assign head     = mem_flat[rd_q*CODE_W +: CODE_W];
  assign nonempty = (occ_q != '0);
  assign occ_o    = occ_q;

  // R7: pushes never exceed the free slots
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n != 2'd0) |-> (int'(occ_q) + int'(push_n) - int'(pop_eff)) <= DEPTH);
endmodule

// File: rtl/seq_status_rlc.sv
module seq_status_rlc
  import rlc_pkg::*;
#(
  parameter int MAX_RUN  = 12,
  parameter int RUN_BASE = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [4:0] in_code,
  output logic       in_ready,
  input  logic       capture,
  input  logic       flush,
  output logic       out_valid,
  output logic [4:0] out_code,
  input  logic       out_ready
);
  localparam int DEPTH = 3;
  localparam int OW    = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(MAX_RUN + 1);

  logic [1:0]       push_n;
  code_t            push0, push1, head;
  logic [OW-1:0]    occ;
  logic [CNT_W-1:0] cnt;
  logic             acc, nonempty;

  assign in_ready = (occ < OW'(2));
  assign acc      = in_valid & in_ready;

  rlc_accum #(.MAX_RUN(MAX_RUN), .RUN_BASE(RUN_BASE)) u_accum (
    .clk(clk), .rst_n(rst_n), .acc(acc), .code(in_code),
    .capture(capture), .flush(flush), .room_i(occ < OW'(DEPTH)),
    .push_n(push_n), .push0(push0), .push1(push1), .cnt_o(cnt));

  rlc_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .d0(push0), .d1(push1),
    .pop(out_ready), .head(head), .nonempty(nonempty), .occ_o(occ));

  assign out_valid = nonempty;
  assign out_code  = head;

  // R1: nothing is offered right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
  // R7: held entry stays put under back-pressure
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));
  // R8: the unused reserved code never leaves
  a_r8_no_base_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_code != 5'(RUN_BASE));
  // R2: a lone non-sequential code reaches the output next cycle
  a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_code != SEQ_CODE && cnt == '0 && occ == '0)
      |=> (out_valid && out_code == $past(in_code)));
endmodule

// File: tb/seq_status_rlc_test.sv
`timescale 1ns/1ps
module seq_status_rlc_test;
  localparam int MAXR = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, capture = 0, flush = 0, out_ready = 0;
  logic [4:0] in_code = 0;
  logic in_ready, out_valid;
  logic [4:0] out_code;

  int checks = 0, errors = 0;
  logic [4:0] eq_code [64];
  string      eq_tag  [64];
  int eq_rd = 0, eq_wr = 0, eq_n = 0, mcnt = 0;
  logic bp = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic hold_prev = 0;
  logic [4:0] prev_code = 0;
  string phase = "R2";

  always #2.5 clk = ~clk;

  seq_status_rlc uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .in_ready(in_ready), .capture(capture), .flush(flush), .out_valid(out_valid),
    .out_code(out_code), .out_ready(out_ready));

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mpush(input int c, input string tag);
    eq_code[eq_wr] = 5'(c);
    eq_tag[eq_wr]  = tag;
    eq_wr = (eq_wr + 1) % 64;
    eq_n++;
  endtask

  function automatic int runc(input int n);
    return (n == 1) ? 1 : 19 + n;
  endfunction

  task automatic cyc(input logic v, input int c, input logic cp, input logic fl,
                     output logic accepted);
    @(negedge clk);
    in_valid = v; in_code = 5'(c); capture = cp; flush = fl;
    out_ready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    if (hold_prev)
      chk("R7 hold", out_valid && out_code == prev_code, int'(out_code), int'(prev_code));
    chk("R7 valid", out_valid == (eq_n > 0), int'(out_valid), int'(eq_n > 0));
    if (eq_n <= 1) chk("R7 ready", in_ready == 1'b1, int'(in_ready), 1);
    if (out_valid) chk("R8", out_code != 5'd20, int'(out_code), 0);
    if (out_valid && out_ready && eq_n > 0) begin
      chk(eq_tag[eq_rd], out_code == eq_code[eq_rd], int'(out_code), int'(eq_code[eq_rd]));
      eq_rd = (eq_rd + 1) % 64;
      eq_n--;
    end
    hold_prev = out_valid && !out_ready;
    prev_code = out_code;
    accepted = v && in_ready;
    if (accepted) begin
      if (c == 1) begin
        mcnt++;
        if (mcnt == MAXR) begin mpush(runc(MAXR), "R4 saturate"); mcnt = 0; end
      end else begin
        if (mcnt > 0) mpush(runc(mcnt), phase);
        mpush(c, phase);
        mcnt = 0;
      end
    end
    if ((cp || fl) && mcnt > 0) begin mpush(runc(mcnt), phase); mcnt = 0; end
  endtask

  task automatic send(input int c, input logic cp);
    logic a;
    logic first;
    first = 1'b1;
    a = 1'b0;
    while (!a) begin
      cyc(1'b1, c, cp && first, 1'b0, a);
      first = 1'b0;
    end
  endtask

  task automatic idle(input int n, input logic cp, input logic fl);
    logic a;
    for (int i = 0; i < n; i++) cyc(1'b0, 0, cp && i == 0, fl && i == 0, a);
  endtask

  task automatic drain_all();
    logic a;
    int guard;
    guard = 0;
    while ((eq_n > 0 || out_valid) && guard < 200) begin cyc(1'b0, 0, 1'b0, 1'b0, a); guard++; end
  endtask

  task automatic sweep();
    for (int trig = 0; trig < 3; trig++) begin
      for (int n = 0; n <= 2 * MAXR + 1; n++) begin
        phase = (trig == 0) ? "R3" : (trig == 1) ? "R5" : "R6";
        if (bp) phase = {phase, " R7"};
        for (int k = 0; k < n; k++) send(1, 1'b0);
        if (trig == 0) send((n % 18) + 2, 1'b0);
        else idle(1, trig == 1, trig == 2);
      end
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", out_valid == 1'b0, int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 ready", in_ready == 1'b1, int'(in_ready), 1);
    chk("R1 valid", out_valid == 1'b0, int'(out_valid), 0);

    // R2: pass-through sweep of all non-reserved, non-sequential codes
    phase = "R2";
    send(0, 1'b0);
    for (int c = 2; c < 20; c++) send(c, 1'b0);
    drain_all();

    // R3/R5/R6 sweeps, then again under back-pressure (R7)
    sweep();
    drain_all();
    bp = 1'b1;
    sweep();
    bp = 1'b0;
    drain_all();

    // R4: ten ones give one entry of code 29
    phase = "R4 ten";
    for (int k = 0; k < 10; k++) send(1, 1'b0);
    send(3, 1'b0);
    drain_all();

    // R5: capture with the last accepted one counts it
    for (int n = 1; n <= MAXR + 2; n++) begin
      phase = "R5 same-cycle";
      for (int k = 0; k < n; k++) send(1, k == n - 1);
    end
    drain_all();

    // R6: flush with nothing pending emits nothing
    idle(1, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 0, 1'b0, 1'b0, a);
      chk("R6 empty flush", out_valid == 1'b0, int'(out_valid), 0);
    end

    // R1: reset discards a partial run
    for (int k = 0; k < 5; k++) send(1, 1'b0);
    @(negedge clk); in_valid = 0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; mcnt = 0; hold_prev = 0;
    phase = "R1 after reset";
    send(7, 1'b0);
    drain_all();
    chk("R1 queue empty", eq_n == 0, eq_n, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule